// File: doc/BRIEF.md
# Supervisory Interrupt Request Controller

This block drives the active-low interrupt line of a supply supervisor. Six voltage-monitor fault flags, each covering an undervoltage or an overvoltage condition, can act as interrupt sources. Each flag has its own source-enable bit. A watchdog timeout pulse is a seventh source, and a separate enable turns that source off. When an enabled source becomes active, the line goes low and stays low until the source is gone and a clear event arrives.

A clear event is any of the following:
- a release pulse from either reset timer;
- a rising edge on the asynchronous watchdog-input line, resynchronized inside the block;
- a write of the clear code to the command port.

No interrupt is raised while the supervisor is blanked. The supervisor is blanked during power-on sequencing, until every reset output has cleared and its timeout has run out. It is also blanked during power-off sequencing and while forced shutdown is asserted.

Top module: `supv_irq_ctrl`

## Requirements
- R1: While `pup_busy_i` is high, `irq_n_o` is high from the next clock on, whatever the sources do. Any pending interrupt is dropped and does not reappear after blanking ends.
- R2: `pdn_busy_i` high or `fshut_i` high blanks the interrupt in the same way as R1.
- R3: Fault bit i counts as a source only when `fault_en_i[i]` is 1. A fault on a channel whose enable is 0 leaves `irq_n_o` unchanged.
- R4: When an enabled fault is present and the block is not blanked, `irq_n_o` is low from the next clock edge and stays low as long as the fault is present.
- R5: Once all sources are inactive, `irq_n_o` stays low until a clear event arrives.
- R6: A one-cycle pulse on `rel_a_i` or on `rel_b_i` with no source active sets `irq_n_o` high at the next edge.
- R7: A low-to-high change of `wdi_i` is resynchronized through two flops and edge-detected. It clears the interrupt three clock edges after the change. A steady high level or a falling change of `wdi_i` clears nothing.
- R8: A cycle with `cmd_we_i`=1 and `cmd_data_i`=0x10 clears the interrupt. Any other code, or the code without the write strobe, has no effect.
- R9: If a source is active in the same cycle as a clear event, `irq_n_o` stays low.
- R10: A `wdt_timeout_i` pulse with `wdt_en_i`=1 sets `irq_n_o` low at the next edge and latches it. With `wdt_en_i`=0 the pulse is ignored.
- R11: While `rst_n` is low, `irq_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | 6 | Per-channel UV/OV fault flags |
| fault_en_i | input | 6 | Per-channel source enables |
| wdt_timeout_i | input | 1 | Watchdog timeout pulse |
| wdt_en_i | input | 1 | Watchdog source enable |
| rel_a_i | input | 1 | Release pulse of first reset timer |
| rel_b_i | input | 1 | Release pulse of second reset timer |
| wdi_i | input | 1 | Asynchronous watchdog-input line |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_data_i | input | 8 | Command write data |
| pup_busy_i | input | 1 | Power-on sequencing or post-reset delay in progress |
| pdn_busy_i | input | 1 | Power-off sequencing in progress |
| fshut_i | input | 1 | Forced shutdown asserted |
| irq_n_o | output | 1 | Registered active-low interrupt |

## Verification
The bench builds the block with its default parameters: six channels, an 8-bit command port with clear code 0x10, and a two-stage synchronizer. With these values the lowest and highest channels can be exercised alone, and the disabled-channel case uses a middle bit. The clear code can be compared against a code that differs from it in one bit. The three-edge latency of the watchdog-input clear is short enough to check both that a rising change clears and that a held or falling level clears nothing.

// File: rtl/supv_irq_pkg.sv
package supv_irq_pkg;
  localparam int unsigned CMD_W = 8;
  localparam logic [CMD_W-1:0] CLR_CODE = 8'h10;

  // software clear hit
  function automatic logic is_clr_cmd(input logic we, input logic [CMD_W-1:0] data);
    return we && (data == CLR_CODE);
  endfunction

  // next interrupt-active state: blank wins, then set, then clear, else hold
  function automatic logic irq_next(input logic blank, input logic src,
                                    input logic clr, input logic cur);
    if (blank)    return 1'b0;
    else if (src) return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction
endpackage

// File: rtl/supv_irq_sync.sv
module supv_irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= async_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] && !prev_q;

  // R7: edge detector yields single-cycle pulses
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/supv_irq_srcsel.sv
module supv_irq_srcsel #(
  parameter int unsigned NUM_CH = 6
) (
  input  logic [NUM_CH-1:0] fault_i,
  input  logic [NUM_CH-1:0] fault_en_i,
  input  logic              wdt_timeout_i,
  input  logic              wdt_en_i,
  output logic              fault_act_o,
  output logic              src_o
);
  logic [NUM_CH-1:0] sel;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      assign sel[g] = fault_i[g] & fault_en_i[g];
    end
  endgenerate

  assign fault_act_o = |sel;
  assign src_o       = fault_act_o | (wdt_timeout_i & wdt_en_i);

  // R3: no enabled channel faulting means no fault source
  always_comb begin
    a_r3_masked: assert (((fault_i & fault_en_i) != '0) || !fault_act_o);
  end
endmodule

// File: rtl/supv_irq_latch.sv
module supv_irq_latch
  import supv_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic blank_i,
  input  logic src_i,
  input  logic fault_act_i,
  input  logic clr_i,
  output logic irq_n_o
);
  logic irq_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n_q <= 1'b1;
    else        irq_n_q <= !irq_next(blank_i, src_i, clr_i, !irq_n_q);
  end

  assign irq_n_o = irq_n_q;

  // R1 / R2: blanking forces the line inactive
  a_r1_blank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    blank_i |=> irq_n_q);
  // R4: enabled fault holds the line low
  a_r4_fault_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_i && fault_act_i) |=> !irq_n_q);
  // R9: fault beats a clear request
  a_r9_fault_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_i && src_i && clr_i) |=> !irq_n_q);
  // R6: clear with no source releases the line
  a_r6_clear_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_i && !src_i && clr_i) |=> irq_n_q);
  // R5: with no event the line keeps its level
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_i && !src_i && !clr_i) |=> $stable(irq_n_q));
endmodule

// File: rtl/supv_irq_ctrl.sv
module supv_irq_ctrl
  import supv_irq_pkg::*;
#(
  parameter int unsigned NUM_CH      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] fault_i,
  input  logic [NUM_CH-1:0] fault_en_i,
  input  logic              wdt_timeout_i,
  input  logic              wdt_en_i,
  input  logic              rel_a_i,
  input  logic              rel_b_i,
  input  logic              wdi_i,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_data_i,
  input  logic              pup_busy_i,
  input  logic              pdn_busy_i,
  input  logic              fshut_i,
  output logic              irq_n_o
);
  logic wdi_rise;
  logic fault_act;
  logic src_act;
  logic sw_clr;
  logic clr_evt;
  logic blank;

  supv_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(wdi_i), .rise_o(wdi_rise)
  );

  supv_irq_srcsel #(.NUM_CH(NUM_CH)) u_src (
    .fault_i(fault_i), .fault_en_i(fault_en_i),
    .wdt_timeout_i(wdt_timeout_i), .wdt_en_i(wdt_en_i),
    .fault_act_o(fault_act), .src_o(src_act)
  );

  assign sw_clr  = is_clr_cmd(cmd_we_i, cmd_data_i);
  assign clr_evt = rel_a_i | rel_b_i | wdi_rise | sw_clr;
  assign blank   = pup_busy_i | pdn_busy_i | fshut_i;

  supv_irq_latch u_latch (
    .clk(clk), .rst_n(rst_n), .blank_i(blank), .src_i(src_act),
    .fault_act_i(fault_act), .clr_i(clr_evt), .irq_n_o(irq_n_o)
  );

  // R8: a non-matching write is not a clear
  always_comb begin
    a_r8_code_exact: assert (!sw_clr || (cmd_we_i && cmd_data_i == 8'h10));
  end
endmodule

// File: tb/supv_irq_ctrl_bench.sv
module supv_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] fault_i = '0, fault_en_i = '0;
  logic       wdt_timeout_i = 0, wdt_en_i = 0, rel_a_i = 0, rel_b_i = 0;
  logic       wdi_i = 0, cmd_we_i = 0;
  logic [7:0] cmd_data_i = '0;
  logic       pup_busy_i = 0, pdn_busy_i = 0, fshut_i = 0;
  logic       irq_n_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  supv_irq_ctrl u_supv_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .fault_en_i(fault_en_i),
    .wdt_timeout_i(wdt_timeout_i), .wdt_en_i(wdt_en_i),
    .rel_a_i(rel_a_i), .rel_b_i(rel_b_i), .wdi_i(wdi_i),
    .cmd_we_i(cmd_we_i), .cmd_data_i(cmd_data_i),
    .pup_busy_i(pup_busy_i), .pdn_busy_i(pdn_busy_i), .fshut_i(fshut_i),
    .irq_n_o(irq_n_o)
  );

  typedef struct packed {
    logic [5:0] f;
    logic [5:0] e;
    logic       wto, wen, ra, rb, we;
    logic [7:0] cmd;
    logic       pup, pdn, fs;
    logic       exp_n;
    logic [7:0] req;
  } vec_t;

  // f, e, {wto,wen,ra,rb,we}, cmd, {pup,pdn,fs}, expected irq_n, requirement
  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    {6'h00, 6'h00, 5'b00000, 8'h00, 3'b000, 1'b1, 8'd11}, // R11 idle after reset
    {6'h01, 6'h01, 5'b00000, 8'h00, 3'b000, 1'b0, 8'd4},  // R4 channel 0
    {6'h01, 6'h01, 5'b00100, 8'h00, 3'b000, 1'b0, 8'd9},  // R9 clear under fault
    {6'h00, 6'h01, 5'b00000, 8'h00, 3'b000, 1'b0, 8'd5},  // R5 latched
    {6'h00, 6'h01, 5'b00100, 8'h00, 3'b000, 1'b1, 8'd6},  // R6 release A
    {6'h04, 6'h3B, 5'b00000, 8'h00, 3'b000, 1'b1, 8'd3},  // R3 disabled channel
    {6'h20, 6'h20, 5'b00000, 8'h00, 3'b000, 1'b0, 8'd4},  // R4 channel 5
    {6'h00, 6'h20, 5'b00010, 8'h00, 3'b000, 1'b1, 8'd6},  // R6 release B
    {6'h00, 6'h00, 5'b10000, 8'h00, 3'b000, 1'b1, 8'd10}, // R10 disabled watchdog
    {6'h00, 6'h00, 5'b11000, 8'h00, 3'b000, 1'b0, 8'd10}, // R10 watchdog sets
    {6'h00, 6'h00, 5'b01000, 8'h00, 3'b000, 1'b0, 8'd10}, // R10 latched
    {6'h00, 6'h00, 5'b00001, 8'h11, 3'b000, 1'b0, 8'd8},  // R8 wrong code
    {6'h00, 6'h00, 5'b00000, 8'h10, 3'b000, 1'b0, 8'd8},  // R8 no strobe
    {6'h00, 6'h00, 5'b00001, 8'h10, 3'b000, 1'b1, 8'd8},  // R8 clear code
    {6'h02, 6'h02, 5'b00000, 8'h00, 3'b100, 1'b1, 8'd1},  // R1 power-on blank
    {6'h00, 6'h00, 5'b11000, 8'h00, 3'b010, 1'b1, 8'd2},  // R2 power-off blank
    {6'h02, 6'h02, 5'b00000, 8'h00, 3'b001, 1'b1, 8'd2},  // R2 shutdown blank
    {6'h00, 6'h00, 5'b11000, 8'h00, 3'b000, 1'b0, 8'd10}, // R10 set again
    {6'h00, 6'h00, 5'b00000, 8'h00, 3'b010, 1'b1, 8'd2},  // R2 blank drops latch
    {6'h00, 6'h00, 5'b11100, 8'h00, 3'b000, 1'b0, 8'd9}   // R9 set beats clear
  };

  task automatic check(input logic exp, input int req, input string what);
    checks++;
    if (irq_n_o !== exp) begin
      errors++;
      $display("FAIL R%0d %s: irq_n_o=%b expected %b", req, what, irq_n_o, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    fault_i = v.f; fault_en_i = v.e;
    {wdt_timeout_i, wdt_en_i, rel_a_i, rel_b_i, cmd_we_i} = {v.wto, v.wen, v.ra, v.rb, v.we};
    cmd_data_i = v.cmd;
    {pup_busy_i, pdn_busy_i, fshut_i} = {v.pup, v.pdn, v.fs};
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    apply('0);
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run hung, irq_n_o=%b expected completion", irq_n_o);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R11: reset holds the line inactive even with an enabled fault
    fault_i = 6'h01; fault_en_i = 6'h01;
    repeat (3) @(negedge clk);
    check(1'b1, 11, "during reset");
    fault_i = '0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      check(TBL[i].exp_n, int'(TBL[i].req), $sformatf("vector %0d", i));
    end

    // R7: rising watchdog-input edge clears after the synchronizer
    idle(1);
    check(1'b0, 7, "before wdi edge");
    wdi_i = 1'b1;
    @(negedge clk); @(negedge clk);
    check(1'b0, 7, "two edges after wdi rise");
    @(negedge clk);
    check(1'b1, 7, "three edges after wdi rise");
    // R7: held high level does not clear
    apply('{f:6'h00, e:6'h00, wto:1'b1, wen:1'b1, ra:1'b0, rb:1'b0, we:1'b0,
            cmd:8'h00, pup:1'b0, pdn:1'b0, fs:1'b0, exp_n:1'b0, req:8'd10});
    idle(5);
    check(1'b0, 7, "wdi held high");
    // R7: falling change does not clear
    wdi_i = 1'b0;
    idle(5);
    check(1'b0, 7, "wdi falling");
    wdi_i = 1'b1;
    idle(5);
    check(1'b1, 7, "second wdi rise");

    // R11: reset mid-run with an active latch
    apply('{f:6'h08, e:6'h08, wto:1'b0, wen:1'b0, ra:1'b0, rb:1'b0, we:1'b0,
            cmd:8'h00, pup:1'b0, pdn:1'b0, fs:1'b0, exp_n:1'b0, req:8'd4});
    check(1'b0, 4, "channel 3 sets");
    rst_n = 1'b0;
    #1;
    check(1'b1, 11, "async reset");
    fault_i = '0;
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    check(1'b1, 11, "after reset release");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule